// File: doc/BRIEF.md
# Multicycle AES-128 Encryption Core

This block encrypts one 128-bit plaintext block under a 128-bit key. It has a single round datapath that is reused across many clock cycles, and a round-key generator that derives each round key from the previous one while the rounds run. One controller state machine sequences both units through enable lines, much as a multicycle processor drives a shared ALU. It does not use a separate state machine per unit.

A host applies the plaintext and the key and pulses `start` for one cycle. The core performs three steps:

- On the edge that samples `start`, it applies the initial key addition.
- On the ten edges that follow, it runs one full round per edge.
- It then raises `done` for a single cycle.

The ciphertext stays on `cipher_text` until the next accepted start. The round counter has one fixed origin: it reads 1 during the first full round and `NUM_ROUNDS` during the last one, and it is 0 whenever no round is running.

The controller has three states. **IDLE** waits for `start`. **ROUND** applies one round per cycle. **DONE** presents the result for one cycle. It has five transitions:

- IDLE→ROUND when `start` is seen.
- ROUND→ROUND while the counter is below `NUM_ROUNDS`.
- ROUND→DONE on the last round.
- DONE→ROUND when `start` arrives in the done cycle (back-to-back launch).
- DONE→IDLE otherwise.

Top module: `aes_mc_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `done` is 0 and `cipher_text` is all zeros.
- R2: Bytes are packed with byte 0 in bits [127:120] and byte 15 in bits [7:0], and the state is filled column by column (byte 4c+r at row r, column c). Under this packing, key 000102…0E0F with plaintext 00112233…EEFF gives 69C4E0D86A7B0430D8CDB78070B4C55A.
- R3: For any plaintext and key, the result equals the following sequence: an initial XOR with the key, then nine rounds of S-box substitution, row rotation (row r rotated left by r bytes), column mixing and round-key XOR, then a tenth round that skips the column mixing.
- R4: The round keys follow the AES-128 expansion. Each key comes from the previous one by word rotation, S-box substitution and XOR with the round constants 01,02,04,08,10,20,40,80,1B,36 in that order. Key 2B7E1516…09CF4F3C with plaintext 3243F6A8…E0370734 gives 3925841D02DC09FBDC118597196A0B32.
- R5: `done` rises on the 10th rising edge after the edge that samples `start`, and it is high for exactly one cycle.
- R6: Once `done` has been high, `cipher_text` holds its value while `start` stays low, whatever `plain_text` and `cipher_key` do.
- R7: A `start` pulse while rounds are running has no effect: the result and the `done` timing are those of the encryption already in progress.
- R8: A `start` in the cycle where `done` is high begins a new encryption at once, with the counter back at 1. That encryption produces the correct ciphertext for the new inputs after the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to encrypt the present inputs |
| plain_text | input | 128 | Plaintext block, byte 0 in the top bits |
| cipher_key | input | 128 | Cipher key, byte 0 in the top bits |
| cipher_text | output | 128 | Ciphertext; valid from the `done` cycle until the next accepted start |
| done | output | 1 | One-cycle pulse when `cipher_text` is valid |

## Verification
The hardest situations to reach from the ports involve `start` arriving at awkward moments: in the middle of the round sequence, and in the very cycle that `done` is high. The bench places these pulses by counting falling edges from the launching edge. It fires one spurious start four cycles into a run with different data on the inputs, and it fires another start with fresh data at the falling edge where `done` is first seen. Each resulting ciphertext is compared with a bench-side model of the cipher, and the number of edges until `done` is checked against the required latency.

// File: rtl/aes_mc_pkg.sv
package aes_mc_pkg;

    localparam int unsigned BLK_W    = 128;
    localparam int unsigned NBYTES   = BLK_W / 8;
    localparam int unsigned NWORDS   = BLK_W / 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_DONE  = 2'd2
    } ctrl_state_e;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_xtime(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = gf_xtime(aa);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse (and maps 0 to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] base;
        logic [7:0] ex;
        res  = 8'h01;
        base = a;
        ex   = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            if (ex[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    function automatic logic [7:0] sbox_fn(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // round constant for step idx (0 gives 01)
    function automatic logic [7:0] rcon_fn(input int idx);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < 16; i++) begin
            if (i < idx) r = gf_xtime(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/aes_ctrl.sv
module aes_ctrl
    import aes_mc_pkg::*;
#(
    parameter int unsigned NUM_ROUNDS = 10,
    parameter int unsigned RND_W      = $clog2(NUM_ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             ld_en,
    output logic             adv_en,
    output logic             skip_mix,
    output logic             done,
    output logic             busy,
    output logic [RND_W-1:0] rnd
);

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS);

    ctrl_state_e state_q, state_d;
    logic        last_rnd;

    assign last_rnd = (rnd == LAST_RND);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ROUND;
            ST_ROUND: if (last_rnd) state_d = ST_DONE;
            ST_DONE:  state_d = start ? ST_ROUND : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_en    = 1'b0;
        adv_en   = 1'b0;
        skip_mix = 1'b0;
        done     = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ld_en = start;
            end
            ST_ROUND: begin
                adv_en   = 1'b1;
                busy     = 1'b1;
                skip_mix = last_rnd;
            end
            ST_DONE: begin
                done  = 1'b1;
                ld_en = start;
            end
            default: ;
        endcase
    end

    // counter origin: 1 in the first full round, 0 whenever idle
    always_ff @(posedge clk) begin
        if (!rst_n)                 rnd <= '0;
        else if (ld_en)             rnd <= RND_W'(1);
        else if (adv_en && last_rnd) rnd <= '0;
        else if (adv_en)            rnd <= rnd + 1'b1;
    end

endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import aes_mc_pkg::*;
#(
    parameter int unsigned RND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             adv_en,
    input  logic [BLK_W-1:0] key_in,
    input  logic [RND_W-1:0] rnd,
    output logic [BLK_W-1:0] rk_next
);

    logic [BLK_W-1:0] rk_q;
    logic [31:0]      w_cur [NWORDS];
    logic [31:0]      w_nxt [NWORDS];
    logic [31:0]      rot_sub;
    logic [7:0]       rc;

    assign rc = rcon_fn(int'(rnd) - 1);

    for (genvar i = 0; i < NWORDS; i++) begin : g_split
        assign w_cur[i] = rk_q[BLK_W-1-32*i -: 32];
    end

    assign rot_sub = {sbox_fn(w_cur[NWORDS-1][23:16]), sbox_fn(w_cur[NWORDS-1][15:8]),
                      sbox_fn(w_cur[NWORDS-1][7:0]),   sbox_fn(w_cur[NWORDS-1][31:24])}
                     ^ {rc, 24'h000000};

    assign w_nxt[0] = w_cur[0] ^ rot_sub;
    for (genvar i = 1; i < NWORDS; i++) begin : g_chain
        assign w_nxt[i] = w_cur[i] ^ w_nxt[i-1];
    end

    for (genvar i = 0; i < NWORDS; i++) begin : g_join
        assign rk_next[BLK_W-1-32*i -: 32] = w_nxt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rk_q <= '0;
        else if (ld_en)  rk_q <= key_in;
        else if (adv_en) rk_q <= rk_next;
    end

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
    import aes_mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             adv_en,
    input  logic             skip_mix,
    input  logic [BLK_W-1:0] plain_in,
    input  logic [BLK_W-1:0] key_in,
    input  logic [BLK_W-1:0] rkey,
    output logic [BLK_W-1:0] st_q
);

    logic [7:0]       sb [NBYTES];
    logic [7:0]       sr [NBYTES];
    logic [7:0]       mc [NBYTES];
    logic [BLK_W-1:0] sr_v;
    logic [BLK_W-1:0] mc_v;
    logic [BLK_W-1:0] rnd_out;

    // byte k sits at row k%4, column k/4
    for (genvar k = 0; k < NBYTES; k++) begin : g_sub
        assign sb[k] = sbox_fn(st_q[BLK_W-1-8*k -: 8]);
    end

    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign sr[4*c+r] = sb[4*((c+r)%4)+r];
        end
        logic [7:0] a0, a1, a2, a3;
        assign a0 = sr[4*c+0];
        assign a1 = sr[4*c+1];
        assign a2 = sr[4*c+2];
        assign a3 = sr[4*c+3];
        assign mc[4*c+0] = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
        assign mc[4*c+1] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
        assign mc[4*c+2] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
        assign mc[4*c+3] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_pack
        assign sr_v[BLK_W-1-8*k -: 8] = sr[k];
        assign mc_v[BLK_W-1-8*k -: 8] = mc[k];
    end

    assign rnd_out = (skip_mix ? sr_v : mc_v) ^ rkey;

    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '0;
        else if (ld_en)  st_q <= plain_in ^ key_in;
        else if (adv_en) st_q <= rnd_out;
    end

endmodule

// File: rtl/aes_mc_core.sv
module aes_mc_core
    import aes_mc_pkg::*;
#(
    parameter int unsigned NUM_ROUNDS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [127:0] plain_text,
    input  logic [127:0] cipher_key,
    output logic [127:0] cipher_text,
    output logic         done
);

    localparam int unsigned RND_W = $clog2(NUM_ROUNDS + 1);

    logic             ld_en;
    logic             adv_en;
    logic             skip_mix;
    logic             busy;
    logic [RND_W-1:0] rnd;
    logic [BLK_W-1:0] rk_next;

    aes_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .RND_W(RND_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ld_en    (ld_en),
        .adv_en   (adv_en),
        .skip_mix (skip_mix),
        .done     (done),
        .busy     (busy),
        .rnd      (rnd)
    );

    aes_key_sched #(.RND_W(RND_W)) u_ks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .adv_en  (adv_en),
        .key_in  (cipher_key),
        .rnd     (rnd),
        .rk_next (rk_next)
    );

    aes_round_dp u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .adv_en   (adv_en),
        .skip_mix (skip_mix),
        .plain_in (plain_text),
        .key_in   (cipher_key),
        .rkey     (rk_next),
        .st_q     (cipher_text)
    );

endmodule

// File: rtl/aes_mc_chk.sv
module aes_mc_chk #(
    parameter int unsigned NUM_ROUNDS = 10,
    parameter int unsigned RND_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             busy,
    input logic [RND_W-1:0] rnd,
    input logic [127:0]     cipher
);

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R5
    AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd == LAST_RND) |=> done);                               // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cipher));                            // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd != LAST_RND) |=> (busy && rnd == $past(rnd) + 1'b1)); // R7
    AST_RND_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rnd == RND_W'(1));                                 // R8
    AST_RND_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rnd == '0);                                              // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && cipher == '0));                               // R1

endmodule

bind aes_mc_core aes_mc_chk #(.NUM_ROUNDS(NUM_ROUNDS), .RND_W(RND_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .rnd    (rnd),
    .cipher (cipher_text)
);

// File: tb/sim_aes_mc_core.sv
`timescale 1ns/1ps
module sim_aes_mc_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] plain = '0;
    logic [127:0] keyi = '0;
    logic [127:0] cipher;
    logic         done;

    int checks = 0;
    int errors = 0;
    logic [7:0] sbx [256];

    localparam int EXP_LAT = 11; // falling edges from the start edge to done seen (10 edges + 1)

    always #10 clk = ~clk; // 50 MHz

    aes_mc_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .plain_text  (plain),
        .cipher_key  (keyi),
        .cipher_text (cipher),
        .done        (done)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] m2(input logic [7:0] b);
        return (b << 1) ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = m2(x);
            y = y >> 1;
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] o;
            logic [7:0] cst = 8'h63;
            for (int y = 1; y < 256; y++)
                if (pmul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
            for (int b = 0; b < 8; b++)
                o[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ cst[b];
            sbx[v] = o;
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] k);
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [7:0]  a [4];
        logic [31:0] w [44];
        logic [31:0] tmp;
        logic [7:0]  rc = 8'h01;
        logic [127:0] o;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sbx[tmp[23:16]], sbx[tmp[15:8]], sbx[tmp[7:0]], sbx[tmp[31:24]]} ^ {rc, 24'h0};
                rc = m2(rc);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int i = 0; i < 16; i++) t[i] = sbx[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
            if (rd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    for (int r = 0; r < 4; r++) a[r] = s[4*c+r];
                    for (int r = 0; r < 4; r++)
                        s[4*c+r] = m2(a[r]) ^ m2(a[(r+1)%4]) ^ a[(r+1)%4] ^ a[(r+2)%4] ^ a[(r+3)%4];
                end
            end
            for (int i = 0; i < 16; i++) s[i] ^= w[4*rd + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // at a falling edge (if at_neg) or after waiting for one: apply inputs and start,
    // then count falling edges after the sampling edge until done is seen
    task automatic launch(input logic [127:0] pt, input logic [127:0] k, input bit at_neg,
                          output logic [127:0] ct, output int lat);
        if (!at_neg) @(negedge clk);
        plain = pt;
        keyi  = k;
        start = 1'b1;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 40);
        ct = cipher;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {127'b0, done}, 128'b0);
        chk("R1", "cipher in reset", cipher, 128'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", {127'b0, done}, 128'b0);
        chk("R1", "cipher after reset", cipher, 128'b0);
    endtask

    task automatic t_vector(input string req, input logic [127:0] pt, input logic [127:0] k,
                            input logic [127:0] exp);
        logic [127:0] ct;
        int lat;
        launch(pt, k, 1'b0, ct, lat);
        chk(req, "known answer", ct, exp);
        chk("R5", "latency", 128'(lat), 128'(EXP_LAT));
        @(negedge clk);
        chk("R5", "done one cycle", {127'b0, done}, 128'b0);
    endtask

    task automatic t_patterns();
        logic [127:0] pts [5];
        logic [127:0] kys [5];
        pts[0] = '0;            kys[0] = '0;
        pts[1] = '1;            kys[1] = '1;
        pts[2] = {16{8'hA5}};   kys[2] = {16{8'h5A}};
        pts[3] = {$urandom, $urandom, $urandom, $urandom};
        kys[3] = {$urandom, $urandom, $urandom, $urandom};
        pts[4] = {$urandom, $urandom, $urandom, $urandom};
        kys[4] = {$urandom, $urandom, $urandom, $urandom};
        for (int i = 0; i < 5; i++) begin
            logic [127:0] ct;
            int lat;
            launch(pts[i], kys[i], 1'b0, ct, lat);
            chk("R3", "pattern vs model", ct, ref_enc(pts[i], kys[i]));
            chk("R5", "pattern latency", 128'(lat), 128'(EXP_LAT));
        end
    endtask

    task automatic t_hold();
        logic [127:0] ct;
        int lat;
        logic [127:0] pt = 128'h0123456789ABCDEF_FEDCBA9876543210;
        logic [127:0] k  = 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0;
        launch(pt, k, 1'b0, ct, lat);
        for (int i = 0; i < 5; i++) begin
            plain = {$urandom, $urandom, $urandom, $urandom};
            keyi  = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
            chk("R6", "cipher held", cipher, ref_enc(pt, k));
            chk("R6", "no done while held", {127'b0, done}, 128'b0);
        end
    endtask

    task automatic t_ignore();
        logic [127:0] pa = 128'h00000000000000000000000000000001;
        logic [127:0] ka = 128'h80000000000000000000000000000000;
        int lat = 0;
        @(negedge clk);
        plain = pa; keyi = ka; start = 1'b1;
        @(posedge clk);
        do begin
            @(negedge clk);
            lat++;
            start = (lat == 4);
            if (lat == 4) begin
                plain = 128'hDEADBEEF_DEADBEEF_DEADBEEF_DEADBEEF;
                keyi  = 128'hCAFEF00D_CAFEF00D_CAFEF00D_CAFEF00D;
            end
        end while (!done && lat < 40);
        start = 1'b0;
        chk("R7", "mid-run start ignored, result", cipher, ref_enc(pa, ka));
        chk("R7", "mid-run start ignored, latency", 128'(lat), 128'(EXP_LAT));
    endtask

    task automatic t_back_to_back();
        logic [127:0] ct;
        int lat;
        logic [127:0] pa = 128'h11111111222222223333333344444444;
        logic [127:0] ka = 128'h55555555666666667777777788888888;
        logic [127:0] pb = 128'h99999999AAAAAAAABBBBBBBBCCCCCCCC;
        logic [127:0] kb = 128'hDDDDDDDDEEEEEEEEFFFFFFFF00000000;
        launch(pa, ka, 1'b0, ct, lat);
        chk("R8", "first of pair", ct, ref_enc(pa, ka));
        launch(pb, kb, 1'b1, ct, lat); // start in the done cycle
        chk("R8", "second of pair", ct, ref_enc(pb, kb));
        chk("R8", "second latency", 128'(lat), 128'(EXP_LAT));
        @(negedge clk);
        chk("R5", "done drops after pair", {127'b0, done}, 128'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        build_sbox();
        t_reset();
        t_vector("R2", 128'h00112233445566778899AABBCCDDEEFF,
                 128'h000102030405060708090A0B0C0D0E0F,
                 128'h69C4E0D86A7B0430D8CDB78070B4C55A);
        t_vector("R4", 128'h3243F6A8885A308D313198A2E0370734,
                 128'h2B7E151628AED2A6ABF7158809CF4F3C,
                 128'h3925841D02DC09FBDC118597196A0B32);
        t_patterns();
        t_hold();
        t_ignore();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule